// File: doc/BRIEF.md
# LIN Transmitter Guard and Bus Wake Controller

This block is the digital supervisor placed next to a single-wire LIN bus driver. Every cycle it decides whether the low-side transmitter may pull the bus dominant. Three conditions can forbid it:

- a thermal fault,
- a low-voltage shutdown, when that feature is switched on,
- low-power mode.

The driver output is active low. It copies the transmit data while driving is allowed and sits at the recessive (high) level otherwise.

A small control/status register holds the following:

- the slew-rate choice for the analog slope shaper,
- an over-temperature interrupt enable,
- a live over-temperature status bit,
- a sticky wake flag,
- the pending-interrupt bit.

Reading the register acknowledges the interrupt. In low-power mode the receive path stays alive. A dominant pulse on the bus that lasts at least `WAKE_CYC` clock cycles and then returns to recessive is reported as a wake-up.

All the pins here are plain level control and status. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure. Software drives the register port with single-cycle `reg_wr` and `reg_rd` strobes. The thermal, under-voltage and receive inputs each pass through a two-flop synchronizer before any logic uses them.

Top module: `lin_guard_ctrl`

## Requirements
- R1: After reset the slew field is 00, the interrupt enable is 0, the wake flag, status and pending bits are 0, `irq` and `wake_req` are low and `drv_out` is high.
- R2: Register bits [1:0] select the slew rate (00 = 20 kbit/s, 01 = 10 kbit/s, 10 = fast 100 kbit/s) and drive `slew_sel`. A write of 11 leaves the field unchanged.
- R3: While the synchronized thermal fault is asserted, `drv_out` is high and read bit [4] is 1. Bit [4] follows the live condition and is not latched.
- R4: After a thermal fault, driving resumes only once the fault has cleared and `txd_in` has been high in the same cycle. Until then a low `txd_in` still gives a high `drv_out`.
- R5: With the enable (bit [2]) set, the onset of a thermal fault sets the pending bit (read bit [5]) and `irq`. A `reg_rd` strobe clears them.
- R6: A fault that persists does not raise `irq` again after acknowledge. A fault that clears and then returns raises it again.
- R7: With `uvsd_en` high and under-voltage present, a recessive driver stays recessive. A dominant bit in progress completes, and the driver is forced recessive from the next rising `txd_in`. With `uvsd_en` low, under-voltage has no effect on `drv_out`.
- R8: While `lp_req` is high, `drv_out` is high whatever `txd_in` is.
- R9: In low-power mode, a synchronized `rxd_in` low for at least `WAKE_CYC` cycles followed by a rise gives a wake event. A shorter low pulse gives none, and outside low-power mode there is none.
- R10: A wake event gives exactly one cycle of `wake_req` and sets the sticky flag at bit [3]. Writing 1 to bit [3] clears the flag.
- R11: With no disable condition active, `drv_out` equals `txd_in` in the same cycle (low = dominant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Transmit data from the protocol controller, low = dominant |
| rxd_in | input | 1 | Receive comparator output, asynchronous |
| therm_flt | input | 1 | Thermal fault flag, asynchronous |
| uv_flt | input | 1 | Supply under-voltage flag, asynchronous |
| lp_req | input | 1 | Low-power mode request |
| uvsd_en | input | 1 | Enables the low-voltage shutdown behaviour |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, acknowledges the interrupt |
| reg_wdata | input | 4 | Write data: [1:0] slew, [2] interrupt enable, [3] write 1 to clear the wake flag |
| reg_rdata | output | 6 | Read data: [1:0] slew, [2] enable, [3] wake flag, [4] thermal status, [5] pending |
| slew_sel | output | 2 | Slew-rate selection to the analog driver |
| drv_out | output | 1 | Gated driver control, low = dominant |
| irq | output | 1 | Over-temperature interrupt |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
A thermal lock register stuck in the wrong state would show at `drv_out` in the first cycle that `txd_in` goes low. It would appear either as a dominant bit passed through during a fault, or as a bus held recessive after the fault has cleared. A wrong under-voltage lock would show within one cycle of the next `txd_in` edge. An edge detector on the thermal input that lost its history would show at `irq` within three cycles of a fault, or of an acknowledge while the fault persists. A wake counter that miscounts or fails to restart would show as a missing or extra `wake_req` pulse within three cycles of the bus returning recessive.

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;
  typedef enum logic [1:0] {
    SLEW_20K  = 2'b00,
    SLEW_10K  = 2'b01,
    SLEW_FAST = 2'b10,
    SLEW_RSVD = 2'b11
  } slew_e;

  localparam int WDATA_W = 4;
  localparam int RDATA_W = 6;
  localparam int BIT_IE    = 2;
  localparam int BIT_WAKE  = 3;
  localparam int BIT_OTST  = 4;
  localparam int BIT_PEND  = 5;
endpackage

// File: rtl/lgc_sync.sv
module lgc_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lgc_txgate.sv
module lgc_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  input  logic therm_s,
  input  logic uv_s,
  input  logic uvsd_en,
  input  logic lp_req,
  output logic drv_out
);
  logic ot_lock;
  logic uv_lock;
  logic tx_ok;

  // Thermal lock holds until the fault is gone and txd is recessive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_lock <= 1'b0;
      uv_lock <= 1'b0;
    end else begin
      ot_lock <= therm_s | (ot_lock & ~txd);
      // Under-voltage locks only at a recessive point, so a dominant bit completes.
      uv_lock <= uvsd_en & uv_s & (uv_lock | txd);
    end
  end

  assign tx_ok   = ~therm_s & ~ot_lock & ~uv_lock & ~lp_req;
  assign drv_out = txd | ~tx_ok;

  // R4: the thermal lock releases only after a cycle with txd high and no fault
  a_r4_ot_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_lock) |-> ($past(txd) && !$past(therm_s)));

  // R7: the under-voltage lock never cuts a dominant bit short
  a_r7_uv_at_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_lock) |-> $past(txd));
endmodule

// File: rtl/lgc_wake.sv
module lgc_wake #(
  parameter int WAKE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic rx_s,
  output logic wake_pulse
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] THR = CW'(WAKE_CYC);

  logic [CW-1:0] cnt;
  logic          rx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rx_d       <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      rx_d       <= rx_s;
      wake_pulse <= 1'b0;
      if (!lp_req) begin
        cnt <= '0;
      end else if (!rx_s) begin
        if (cnt < THR) cnt <= cnt + 1'b1;
      end else begin
        if (!rx_d && cnt >= THR) wake_pulse <= 1'b1;
        cnt <= '0;
      end
    end
  end

  // R10: the wake request lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R9: a wake event is only produced in low-power mode
  a_r9_lp_only: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(lp_req));
endmodule

// File: rtl/lgc_regs.sv
module lgc_regs
  import lin_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [WDATA_W-1:0] wdata,
  input  logic               therm_s,
  input  logic               wake_ev,
  output logic [RDATA_W-1:0] rdata,
  output logic [1:0]         slew,
  output logic               irq
);
  slew_e slew_q;
  logic  ot_ie;
  logic  wake_flag;
  logic  irq_pend;
  logic  therm_d;
  logic  onset;

  assign onset = therm_s & ~therm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_q    <= SLEW_20K;
      ot_ie     <= 1'b0;
      wake_flag <= 1'b0;
      irq_pend  <= 1'b0;
      therm_d   <= 1'b0;
    end else begin
      therm_d <= therm_s;
      if (wr) begin
        ot_ie <= wdata[BIT_IE];
        if (wdata[1:0] != SLEW_RSVD) slew_q <= slew_e'(wdata[1:0]);
      end
      if (wake_ev)                       wake_flag <= 1'b1;
      else if (wr && wdata[BIT_WAKE])    wake_flag <= 1'b0;
      if (onset && ot_ie)                irq_pend  <= 1'b1;
      else if (rd)                       irq_pend  <= 1'b0;
    end
  end

  assign slew  = slew_q;
  assign irq   = irq_pend;
  assign rdata = {irq_pend, therm_s, wake_flag, ot_ie, slew_q};

  // R5: a pending interrupt only appears with the enable set
  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(ot_ie));

  // R6: a fault that persists does not re-raise an acknowledged interrupt
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_s && therm_d && !irq_pend) |=> !irq_pend);

  // R2: the reserved slew code never lands in the field
  a_r2_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    slew_q != SLEW_RSVD);
endmodule

// File: rtl/lin_guard_ctrl.sv
module lin_guard_ctrl
  import lin_guard_pkg::*;
#(
  parameter int WAKE_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txd_in,
  input  logic               rxd_in,
  input  logic               therm_flt,
  input  logic               uv_flt,
  input  logic               lp_req,
  input  logic               uvsd_en,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic [RDATA_W-1:0] reg_rdata,
  output logic [1:0]         slew_sel,
  output logic               drv_out,
  output logic               irq,
  output logic               wake_req
);
  logic [2:0] async_in;
  logic [2:0] sync_out;
  logic       therm_s;
  logic       uv_s;
  logic       rx_s;

  assign async_in = {rxd_in, uv_flt, therm_flt};

  lgc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out));

  assign therm_s = sync_out[0];
  assign uv_s    = sync_out[1];
  assign rx_s    = sync_out[2];

  lgc_txgate u_gate (
    .clk(clk), .rst_n(rst_n), .txd(txd_in), .therm_s(therm_s), .uv_s(uv_s),
    .uvsd_en(uvsd_en), .lp_req(lp_req), .drv_out(drv_out));

  lgc_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .rx_s(rx_s), .wake_pulse(wake_req));

  lgc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .therm_s(therm_s), .wake_ev(wake_req), .rdata(reg_rdata), .slew(slew_sel),
    .irq(irq));

  // R3: a live thermal fault keeps the bus recessive
  a_r3_therm_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    therm_s |-> drv_out);

  // R8: low-power mode keeps the bus recessive
  a_r8_lp_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> drv_out);
endmodule

// File: tb/tb_lin_guard_ctrl.sv
module tb_lin_guard_ctrl;
  localparam int WAKE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txd_in = 1'b1, rxd_in = 1'b1, therm_flt = 1'b0, uv_flt = 1'b0;
  logic       lp_req = 1'b0, uvsd_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [5:0] reg_rdata;
  logic [1:0] slew_sel;
  logic       drv_out, irq, wake_req;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;

  always #10 clk = ~clk;

  lin_guard_ctrl #(.WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .rxd_in(rxd_in),
    .therm_flt(therm_flt), .uv_flt(uv_flt), .lp_req(lp_req), .uvsd_en(uvsd_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slew_sel(slew_sel), .drv_out(drv_out), .irq(irq), .wake_req(wake_req));

  always @(posedge clk) if (wake_req) wake_cnt <= wake_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 4'h0;
  endtask

  task automatic rd_ack();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 slew", slew_sel, 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 drv", drv_out, 1);
  endtask

  task automatic t_slew();
    wr_reg(4'b0001); cyc(1); chk("R2 10k", slew_sel, 1);
    wr_reg(4'b0010); cyc(1); chk("R2 fast", reg_rdata[1:0], 2);
    wr_reg(4'b0011); cyc(1); chk("R2 rsvd ignored", slew_sel, 2);
    wr_reg(4'b0000); cyc(1); chk("R2 20k", slew_sel, 0);
  endtask

  task automatic t_pass();
    txd_in = 1'b0; cyc(1); chk("R11 dominant", drv_out, 0);
    txd_in = 1'b1; cyc(1); chk("R11 recessive", drv_out, 1);
  endtask

  task automatic t_therm();
    wr_reg(4'b0100);
    txd_in = 1'b0;
    therm_flt = 1'b1; cyc(4);
    chk("R3 drv off", drv_out, 1);
    chk("R3 status", reg_rdata[4], 1);
    chk("R5 irq", irq, 1);
    rd_ack(); cyc(1);
    chk("R5 ack", irq, 0);
    cyc(6);
    chk("R6 persist no irq", irq, 0);
    therm_flt = 1'b0; cyc(4);
    chk("R3 status live", reg_rdata[4], 0);
    chk("R4 still off", drv_out, 1);
    txd_in = 1'b1; cyc(2);
    txd_in = 1'b0; cyc(1);
    chk("R4 resumed", drv_out, 0);
    therm_flt = 1'b1; cyc(4);
    chk("R6 re-arm", irq, 1);
    therm_flt = 1'b0; rd_ack(); txd_in = 1'b1; cyc(4);
    chk("R6 cleared", irq, 0);
  endtask

  task automatic t_uv();
    uvsd_en = 1'b1; txd_in = 1'b1;
    uv_flt = 1'b1; cyc(4);
    txd_in = 1'b0; cyc(1);
    chk("R7 recessive held", drv_out, 1);
    txd_in = 1'b1; uv_flt = 1'b0; cyc(4);
    txd_in = 1'b0; cyc(1);
    chk("R7 released", drv_out, 0);
    uv_flt = 1'b1; cyc(4);
    chk("R7 dominant finishes", drv_out, 0);
    txd_in = 1'b1; cyc(2);
    txd_in = 1'b0; cyc(1);
    chk("R7 forced after rise", drv_out, 1);
    txd_in = 1'b1; uvsd_en = 1'b0; cyc(2);
    txd_in = 1'b0; cyc(1);
    chk("R7 disabled no effect", drv_out, 0);
    uv_flt = 1'b0; txd_in = 1'b1; cyc(4);
  endtask

  task automatic dom_pulse(input int n);
    rxd_in = 1'b0; cyc(n);
    rxd_in = 1'b1; cyc(6);
  endtask

  task automatic t_wake();
    int base;
    lp_req = 1'b1; txd_in = 1'b0; cyc(1);
    chk("R8 lp recessive", drv_out, 1);
    txd_in = 1'b1;
    base = wake_cnt;
    dom_pulse(2 * WAKE);
    chk("R10 one pulse", wake_cnt - base, 1);
    chk("R9 flag", reg_rdata[3], 1);
    wr_reg(4'b1000); cyc(1);
    chk("R10 w1c", reg_rdata[3], 0);
    base = wake_cnt;
    dom_pulse(WAKE / 2);
    chk("R9 short ignored", wake_cnt - base, 0);
    chk("R9 short no flag", reg_rdata[3], 0);
    lp_req = 1'b0; cyc(1);
    base = wake_cnt;
    dom_pulse(2 * WAKE);
    chk("R9 normal mode none", wake_cnt - base, 0);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_slew();
    t_pass();
    t_therm();
    t_uv();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule